// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block presents a five-digit decimal result one digit at a time on a shared four-bit BCD bus. Each digit has its own select line, and only one select line is active in any cycle. The scan starts with the most significant position and walks down to the least significant before it wraps. Time is measured in scan ticks, which are single-cycle enables from a divider outside the block. Every digit window lasts a fixed number of ticks. In the middle of each window an active-low strobe pulse tells a display driver or a host processor to capture the bus.

The leading position is a half digit, so only the values 0 and 1 can appear there. Result digits are copied into the block only when a full scan begins. A single pass over the five positions therefore always shows one consistent result, even when the source changes while the scan is running.

Top module: `bcd_digit_scanner`

## Requirements
- R1: After reset, and until the first tick, `digit_sel_o` is all zero, `bcd_o` is zero and `strobe_no` is high.
- R2: From the first tick on, exactly one bit of `digit_sel_o` is high. Bit k drives digit position k+1, so bit 4 is the most significant position. The scan visits bit 4, 3, 2, 1, 0 and then returns to bit 4.
- R3: Each window lasts `TICKS_PER_WIN` ticks. The first tick opens the bit-4 window. After that, the select line advances on every `TICKS_PER_WIN`-th tick.
- R4: While bit k is selected, `bcd_o` carries latched nibble k. `digits_i[4k+3:4k]` holds position k+1. The bus bits 0 to 3 carry the weights 1, 2, 4 and 8.
- R5: In the most significant window, `bcd_o[0]` equals bit 16 of the latched input and `bcd_o[3:1]` is zero. No other window is masked.
- R6: `strobe_no` is low for exactly one clock in each window. That clock follows the tick which brings the window's tick count to `TICKS_PER_WIN/2`.
- R7: `digits_i` is sampled only on the tick that opens a bit-4 window. Changes at any other time do not reach `bcd_o` until the next scan.
- R8: In a cycle without a tick, `digit_sel_o` and `bcd_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan-rate enable, one cycle wide |
| digits_i | input | 20 | Five BCD nibbles; nibble 0 is the least significant position |
| bcd_o | output | 4 | Shared BCD bus, weights 1/2/4/8 on bits 0..3 |
| digit_sel_o | output | 5 | One-hot digit drive; bit 4 is the most significant position |
| strobe_no | output | 1 | Capture strobe, active low |

## Verification
Two things can happen in the same cycle. The tick that closes the least significant window also wraps the scan and relatches a new result. In that same cycle the source data may be changing. The bench provokes this with back-to-back ticks and with random changes to `digits_i`, some of which land on the wrap tick and some between ticks. A reference model driven by tick counts alone judges `bcd_o`, `digit_sel_o` and `strobe_no` in every cycle, so data that is latched too early or too late shows up as a mismatch on the bus.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
  localparam int unsigned BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int unsigned NUM_DIGITS    = 5,
  parameter int unsigned TICKS_PER_WIN = 8,
  localparam int unsigned IDX_W = $clog2(NUM_DIGITS),
  localparam int unsigned CNT_W = $clog2(TICKS_PER_WIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic             strobe_no
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_WIN - 1);
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(TICKS_PER_WIN / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(NUM_DIGITS - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             strobe_nq;
  logic             win_end;

  assign win_end  = active_q && (cnt_q == CNT_LAST);
  // new scan: first tick after reset, or end of last (LSD) window
  assign load_o   = tick_i && (!active_q || (win_end && idx_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      cnt_q    <= '0;
    end else if (tick_i) begin
      if (!active_q) begin
        active_q <= 1'b1;
        idx_q    <= IDX_TOP;
        cnt_q    <= '0;
      end else if (win_end) begin
        cnt_q <= '0;
        idx_q <= (idx_q == '0) ? IDX_TOP : idx_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_nq <= 1'b1;
    else         strobe_nq <= !(tick_i && active_q && (cnt_q == CNT_PRE));
  end

  assign active_o  = active_q;
  assign idx_o     = idx_q;
  assign strobe_no = strobe_nq;
endmodule

// File: rtl/result_latch.sv
module result_latch
  import bcd_scan_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 5,
  localparam int unsigned IDX_W = $clog2(NUM_DIGITS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
  input  logic                        active_i,
  input  logic [IDX_W-1:0]            idx_i,
  output bcd_t                        bcd_o
);
  bcd_t lat_q [NUM_DIGITS];

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_nib
    bcd_t nxt;
    if (k == NUM_DIGITS - 1) begin : g_half
      assign nxt = {3'b000, digits_i[k*BCD_W]};
    end else begin : g_full
      assign nxt = digits_i[k*BCD_W +: BCD_W];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lat_q[k] <= '0;
      else if (load_i) lat_q[k] <= nxt;
    end
  end

  always_comb begin
    bcd_o = '0;
    for (int k = 0; k < NUM_DIGITS; k++)
      if (active_i && idx_i == IDX_W'(k)) bcd_o = lat_q[k];
  end
endmodule

// File: rtl/digit_decoder.sv
module digit_decoder #(
  parameter int unsigned NUM_DIGITS = 5,
  localparam int unsigned IDX_W = $clog2(NUM_DIGITS)
) (
  input  logic                  active_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [NUM_DIGITS-1:0] sel_o
);
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_sel
    assign sel_o[k] = active_i && (idx_i == IDX_W'(k));
  end
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
  import bcd_scan_pkg::*;
#(
  parameter int unsigned NUM_DIGITS    = 5,
  parameter int unsigned TICKS_PER_WIN = 8,
  localparam int unsigned IDX_W = $clog2(NUM_DIGITS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
  output logic [BCD_W-1:0]            bcd_o,
  output logic [NUM_DIGITS-1:0]       digit_sel_o,
  output logic                        strobe_no
);
  logic             active;
  logic [IDX_W-1:0] idx;
  logic             load;

  scan_timer #(.NUM_DIGITS(NUM_DIGITS), .TICKS_PER_WIN(TICKS_PER_WIN)) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .active_o(active), .idx_o(idx), .load_o(load), .strobe_no(strobe_no)
  );

  result_latch #(.NUM_DIGITS(NUM_DIGITS)) u_latch (
    .clk_i, .rst_ni, .load_i(load), .digits_i,
    .active_i(active), .idx_i(idx), .bcd_o(bcd_o)
  );

  digit_decoder #(.NUM_DIGITS(NUM_DIGITS)) u_dec (
    .active_i(active), .idx_i(idx), .sel_o(digit_sel_o)
  );
endmodule

// File: rtl/bcd_digit_scanner_chk.sv
module bcd_digit_scanner_chk #(
  parameter int unsigned NUM_DIGITS = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic [3:0]            bcd_o,
  input logic [NUM_DIGITS-1:0] digit_sel_o,
  input logic                  strobe_no
);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_sel_o == '0) |-> (strobe_no && bcd_o == '0));

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(digit_sel_o));

  p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((digit_sel_o != $past(digit_sel_o)) && ($past(digit_sel_o) != '0))
      |-> (digit_sel_o == {$past(digit_sel_o[0]), $past(digit_sel_o[NUM_DIGITS-1:1])}));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(digit_sel_o) && $stable(bcd_o)));

  p_half_digit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_sel_o[NUM_DIGITS-1] |-> (bcd_o[3:1] == 3'b000));

  p_strobe_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |=> strobe_no);

  p_strobe_in_win_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |-> (digit_sel_o != '0));
endmodule

bind bcd_digit_scanner bcd_digit_scanner_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk_i, .rst_ni, .tick_i, .bcd_o, .digit_sel_o, .strobe_no
);

// File: tb/tb_bcd_digit_scanner.sv
module tb_bcd_digit_scanner;
  localparam int N = 5;
  localparam int W = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic [N*4-1:0] digits_i = '0;
  logic [3:0]    bcd_o;
  logic [N-1:0]  digit_sel_o;
  logic          strobe_no;

  int n_chk = 0;
  int n_fail = 0;

  bcd_digit_scanner dut (.*);

  always #4 clk_i = ~clk_i;

  // reference model, tick-count based
  bit         started;
  int         t;
  logic [3:0] lat [N];
  bit         exp_strobe_n;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started = 0; t = 0; exp_strobe_n = 1;
      for (int k = 0; k < N; k++) lat[k] = '0;
    end else begin
      exp_strobe_n = 1;
      if (tick_i) begin
        if (!started) begin
          started = 1; t = 0;
        end else begin
          t++;
          if (t % W == W/2) exp_strobe_n = 0;
        end
        if (t % (W*N) == 0)
          for (int k = 0; k < N; k++) lat[k] = digits_i[4*k +: 4];
      end
    end
  end

  function automatic int cur_idx();
    return N - 1 - ((t / W) % N);
  endfunction

  function automatic logic [N-1:0] exp_sel();
    return started ? (N'(1) << cur_idx()) : '0;
  endfunction

  function automatic logic [3:0] exp_bcd();
    int i;
    if (!started) return 4'd0;
    i = cur_idx();
    return (i == N-1) ? {3'b000, lat[i][0]} : lat[i];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_all();
    chk(digit_sel_o == exp_sel(), started ? "R2 R3 digit select" : "R1 digit select",
        digit_sel_o, exp_sel());
    chk(bcd_o == exp_bcd(), "R4 R7 R8 bcd bus", bcd_o, exp_bcd());
    chk(strobe_no == exp_strobe_n, "R6 strobe", strobe_no, exp_strobe_n);
    if (digit_sel_o[N-1])
      chk(bcd_o[3:1] == 3'b000, "R5 half digit", bcd_o, exp_bcd());
  endtask

  // drive at negedge after checking
  task automatic step(input bit tk);
    @(negedge clk_i);
    check_all();
    tick_i = tk;
  endtask

  function automatic logic [N*4-1:0] rand_digits();
    logic [N*4-1:0] d;
    for (int k = 0; k < N-1; k++) d[4*k +: 4] = 4'($urandom_range(0, 9));
    d[4*(N-1) +: 4] = 4'($urandom_range(0, 15));
    return d;
  endfunction

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    digits_i = 20'h9_8765;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: idle until first tick
    repeat (5) step(1'b0);
    // R5: MSD 9 -> shows 1; back-to-back ticks over two scans
    repeat (2 * W * N + 3) step(1'b1);
    // R7: change data between ticks, must not appear mid-scan
    digits_i = 20'h8_1234;
    repeat (10) step(1'b0);
    repeat (W * N) step(1'b1);
    // R5: MSD 8 -> shows 0 after next wrap
    repeat (3) step(1'b0);
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 49) == 0) digits_i = rand_digits();
      step($urandom_range(0, 2) == 0);
    end
    // reset mid-run: R1 again
    @(negedge clk_i);
    rst_ni = 1'b0;
    tick_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) step(1'b0);
    repeat (2 * W * N) step(1'b1);
    step(1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule